// File: doc/BRIEF.md
# Victim Block Buffer

This block is a small fully associative store that sits on the miss path of a first-level cache. Every block the cache evicts is handed to it on the insert port together with its full block address. Because entries are matched on the complete address, any entry can hold a block from any cache set. In effect the buffer adds a few extra ways that all sets share.

When the cache misses, it presents the block address on the probe port. The buffer answers in the same cycle with a hit flag and the block data. On a hit the block moves back into the cache. In that same cycle the cache may pass down the block it displaced, and that block takes over the entry that was just vacated. A probe that misses changes nothing.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty, so a probe of any address returns `probe_hit` low.
- R2: `probe_hit` is high in the same cycle as `probe_valid` exactly when a valid entry holds `probe_addr`, and `probe_data` then carries that entry's data.
- R3: A probe that misses leaves the contents unchanged.
- R4: While an entry is empty, an insert fills the lowest-numbered empty entry and evicts nothing.
- R5: When every entry is valid, an insert of a new address overwrites the entry at a victim pointer. The pointer is 0 after reset, advances by one after each such overwrite, and wraps from ENTRIES-1 to 0.
- R6: An insert whose address is already held replaces that entry's data in place. It adds no second entry and does not move the victim pointer.
- R7: A probe hit with `swap_valid` low empties the hit entry.
- R8: A probe hit with `swap_valid` high writes `swap_addr` and `swap_data` into the hit entry, so the probed address no longer hits.
- R9: An insert presented in a cycle with `probe_valid` high is dropped.
- R10: `swap_valid` has no effect in a cycle without a probe hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Evicted block present |
| ins_addr | input | ADDR_W | Block address of evicted block |
| ins_data | input | DATA_W | Evicted block data |
| probe_valid | input | 1 | Miss probe present |
| probe_addr | input | ADDR_W | Block address being looked up |
| probe_hit | output | 1 | Probe found a valid matching entry |
| probe_data | output | DATA_W | Data of the matching entry |
| swap_valid | input | 1 | Cache returns a displaced block with the probe |
| swap_addr | input | ADDR_W | Block address of displaced block |
| swap_data | input | DATA_W | Displaced block data |

## Verification
On every cycle, the assertions check four things: no probe address matches more than one entry, a probe miss leaves the valid set untouched, a plain hit lowers the occupancy by one while a swapped hit keeps it, and a fresh insert raises the occupancy until the buffer is full. Several behaviours are visible only through the bench's full address sweeps against its own model. These are which entry a full buffer gives up, the in-place update of a repeated address, the dropped insert during a probe, and the stored data.

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  input  logic              swap_valid,
  input  logic [ADDR_W-1:0] swap_addr,
  input  logic [DATA_W-1:0] swap_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [IDX_W-1:0]   vptr;

  logic [ENTRIES-1:0] pmatch, imatch;
  logic [IDX_W-1:0]   pidx, iidx, fidx;
  logic               ihit, has_free;

  always_comb begin
    pidx = '0; iidx = '0; fidx = '0; has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      pmatch[i] = vld[i] && (tag_q[i] == probe_addr);
      imatch[i] = vld[i] && (tag_q[i] == ins_addr);
      if (pmatch[i]) pidx = IDX_W'(i);
      if (imatch[i]) iidx = IDX_W'(i);
      if (!vld[i]) begin fidx = IDX_W'(i); has_free = 1'b1; end
    end
  end

  assign ihit       = |imatch;
  assign probe_hit  = probe_valid && |pmatch;
  assign probe_data = dat_q[pidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      vptr <= '0;
    end else if (probe_valid) begin
      if (probe_hit) begin
        if (swap_valid) begin
          tag_q[pidx] <= swap_addr;
          dat_q[pidx] <= swap_data;
        end else begin
          vld[pidx] <= 1'b0;
        end
      end
    end else if (ins_valid) begin
      if (ihit) begin
        dat_q[iidx] <= ins_data;
      end else if (has_free) begin
        vld[fidx]   <= 1'b1;
        tag_q[fidx] <= ins_addr;
        dat_q[fidx] <= ins_data;
      end else begin
        tag_q[vptr] <= ins_addr;
        dat_q[vptr] <= ins_data;
        vptr <= (vptr == IDX_W'(ENTRIES - 1)) ? '0 : vptr + 1'b1;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pmatch)); // R2
  AST_MISS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_hit |=> $stable(vld)); // R3
  AST_HIT_VACATES: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit && !swap_valid |=> $countones(vld) == $countones($past(vld)) - 1); // R7
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit && swap_valid |=> $countones(vld) == $countones($past(vld))); // R8
  AST_INSERT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !probe_valid && !ihit && !(&vld)
    |=> $countones(vld) == $countones($past(vld)) + 1); // R4
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !probe_valid && (&vld) |=> (&vld)); // R5
endmodule

// File: tb/victim_buffer_tb.sv
module victim_buffer_tb_top;
  localparam int N = 8, AW = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iv = 0, pv = 0, sv = 0;
  logic [AW-1:0] ia = 0, pa = 0, sa = 0;
  logic [DW-1:0] id = 0, sd = 0;
  logic phit;
  logic [DW-1:0] pdat;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  int          m_ptr = 0;

  always #10 clk = ~clk;

  victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(iv), .ins_addr(ia), .ins_data(id),
    .probe_valid(pv), .probe_addr(pa), .probe_hit(phit), .probe_data(pdat),
    .swap_valid(sv), .swap_addr(sa), .swap_data(sd));

  function automatic int m_find(logic [AW-1:0] a);
    for (int k = 0; k < N; k++) if (m_v[k] && m_a[k] == a) return k;
    return -1;
  endfunction

  task automatic m_step();
    int k;
    if (pv) begin
      k = m_find(pa);
      if (k >= 0) begin
        if (sv) begin m_a[k] = sa; m_d[k] = sd; end
        else m_v[k] = 0;
      end
    end else if (iv) begin
      k = m_find(ia);
      if (k >= 0) m_d[k] = id;
      else begin
        k = -1;
        for (int j = N - 1; j >= 0; j--) if (!m_v[j]) k = j;
        if (k >= 0) begin m_v[k] = 1; m_a[k] = ia; m_d[k] = id; end
        else begin
          m_a[m_ptr] = ia; m_d[m_ptr] = id;
          m_ptr = (m_ptr + 1) % N;
        end
      end
    end
  endtask

  task automatic cyc(input string tag, input bit i_v, input logic [AW-1:0] i_a,
                     input logic [DW-1:0] i_d, input bit p_v, input logic [AW-1:0] p_a,
                     input bit s_v, input logic [AW-1:0] s_a, input logic [DW-1:0] s_d);
    int k;
    @(negedge clk);
    iv = i_v; ia = i_a; id = i_d; pv = p_v; pa = p_a; sv = s_v; sa = s_a; sd = s_d;
    #1;
    if (p_v) begin
      k = m_find(p_a);
      checks++;
      if (phit !== (k >= 0) || (k >= 0 && pdat !== m_d[k])) begin
        errors++;
        $display("FAIL %s addr=%0h hit=%0b data=%0h expected hit=%0b data=%0h",
                 tag, p_a, phit, pdat, k >= 0, (k >= 0) ? m_d[k] : '0);
      end
    end
    @(posedge clk);
    m_step();
    #1;
    iv = 0; pv = 0; sv = 0;
  endtask

  // Full probe sweep: hits hand back the same block, so contents stay put.
  task automatic sweep(input string tag);
    int k;
    for (int a = 0; a < (1 << AW); a++) begin
      k = m_find(AW'(a));
      cyc(tag, 0, 0, 0, 1, AW'(a), k >= 0, AW'(a), (k >= 0) ? m_d[k] : '0);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_v[k] = 0; m_a[k] = 0; m_d[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R1 reset empty");
    for (int k = 0; k < N; k++)
      cyc("R4", 1, AW'(k * 17 + 3), DW'(16'h1000 + k), 0, 0, 0, 0, 0);
    sweep("R4 R2 fill");
    cyc("R6", 1, AW'(2 * 17 + 3), 16'hBEEF, 0, 0, 0, 0, 0);
    sweep("R6 update in place");
    for (int k = 0; k < N + 3; k++)
      cyc("R5", 1, AW'(8'hC0 + k), DW'(16'h2000 + k), 0, 0, 0, 0, 0);
    sweep("R5 victim order");
    cyc("R7", 0, 0, 0, 1, 8'hC4, 0, 0, 0);
    sweep("R7 vacate");
    cyc("R4", 1, 8'h55, 16'h5555, 0, 0, 0, 0, 0);
    cyc("R5", 1, 8'h56, 16'h5656, 0, 0, 0, 0, 0);
    sweep("R4 R5 refill");
    cyc("R8", 0, 0, 0, 1, 8'hC9, 1, 8'h77, 16'h7777);
    sweep("R8 swap");
    cyc("R9", 1, 8'h99, 16'h9999, 1, 8'hC8, 1, 8'hC8, 16'h2008);
    cyc("R9", 1, 8'h9A, 16'h9A9A, 1, 8'h01, 0, 0, 0);
    sweep("R9 R3 insert dropped");
    cyc("R10", 0, 0, 0, 1, 8'h02, 1, 8'h88, 16'h8888);
    cyc("R10", 0, 0, 0, 0, 8'h77, 1, 8'h89, 16'h8989);
    sweep("R10 swap ignored");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule